// File: doc/BRIEF.md
# Timer Interrupt Request and Vector Logic

This block collects the interrupt requests of a group of timer submodules that sit behind one shared bus interface. Each submodule has an event flag, which its timer logic sets, and a 3-bit priority level, which software programs. A submodule raises a request when its flag is set and its level is non-zero. The request takes part in arbitration only if its level is above the processor's current interrupt mask. Level 7 always takes part. The block reports the highest level that is taking part.

During an interrupt-acknowledge cycle the processor side gives the level being acknowledged and the identity that won bus-wide arbitration. For the acknowledged level, the block picks the lowest-numbered submodule that is taking part at that level. It presents that submodule's 4-bit arbitration identity, which is a 3-bit module-wide field joined with one bit from the submodule's own control register. When the winning identity equals the presented one, the block returns, one cycle later, an 8-bit vector. The vector's top two bits come from a module-wide base field. Its low six bits are the submodule's number, which is `FIRST_NUM` plus its local index.

Software reaches a small register set through a simple read/write port:
- Address 0 is the global register.
- Addresses 1 to `N_SUB` are the per-submodule control registers.
- Every other address is unused.

Top module: `timer_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_level` is 0 and `vec_valid` is 0.
- R2: A submodule requests only while its event flag (control bit 15) is set and its level field (control bits 10:8) is non-zero. A level of 0 masks it completely.
- R3: A request joins arbitration only if its level is strictly greater than `ipl_mask`, except that level 7 always joins.
- R4: `irq_level` equals the highest level among the requests that join arbitration, or 0 if there are none. `arb_drive` never asserts for an acknowledged level above `irq_level`.
- R5: While `iack_valid` is high and a joining request exists at `iack_level`, `arb_drive` is 1. `arb_id` is then {control bit 4 of the selected submodule, global bits 2:0}. Otherwise `arb_drive` is 0 and `arb_id` is 0.
- R6: When `iack_win_id` equals the presented `arb_id`, the cycle after the acknowledge shows `vec_valid`=1 and `vec` = {global bits 9:8, 6-bit (`FIRST_NUM` + index)}. If the identities differ, `vec_valid` stays 0.
- R7: When several joining requests share the acknowledged level, the lowest-indexed submodule is selected for both identity and vector.
- R8: Unused bits read as 0. In the global register only bits 2:0 and 9:8 are used. In a control register only bits 15, 10:8 and 4 are used. Every address above `N_SUB` reads 0, and writes to unused bits or addresses change nothing.
- R9: The event flag clears only when its register is read while the flag is 1 and the next write to that register has bit 15 = 0. A write of 0 without that read leaves the flag set, and writing 1 never sets it.
- R10: An event pulse on `evt_set[i]` sets flag i. It wins over a clearing write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| evt_set | input | N_SUB | Per-submodule event pulses that set the flags |
| ipl_mask | input | 3 | Processor's current interrupt mask |
| irq_level | output | 3 | Highest level taking part in arbitration, 0 for none |
| iack_valid | input | 1 | Interrupt-acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| iack_win_id | input | 4 | Identity that won bus-wide arbitration |
| arb_drive | output | 1 | Block is presenting an arbitration identity |
| arb_id | output | 4 | Presented arbitration identity |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec | output | 8 | Interrupt vector |

## Verification
The assertions check on every cycle the following rules:
- Any non-7 `irq_level` stays above the mask.
- The identity is driven only inside an acknowledge and only for a level that `irq_level` covers, and it is zero otherwise.
- A vector appears only the cycle after a driven identity that matched the winning one, and its number lies in the submodule range.
- Unmapped addresses read zero.

Only the bench's scenarios can show the following:
- The exact level chosen.
- Lowest-index selection among tied levels.
- The identity and vector bit layout.
- The read-then-write flag clear and its race against a new event.

To cover these, the bench sweeps sixteen flag and level patterns, with ties, across all masks, levels and winning identities.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int REG_W     = 16;
  localparam int FLAG_BIT  = 15;
  localparam int LVL_LSB   = 8;
  localparam int EXT_BIT   = 4;
  localparam int GARB_LSB  = 0;
  localparam int BASE_LSB  = 8;
  localparam int VNUM_W    = 6;
  typedef logic [2:0] lvl_t;
endpackage

// File: rtl/tic_regs.sv
module tic_regs
  import tic_pkg::*;
#(
  parameter int N_SUB  = 4,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REG_W-1:0]       wdata,
  input  logic [N_SUB-1:0]       evt_set,
  output logic [REG_W-1:0]       rdata,
  output logic [N_SUB-1:0]       flag,
  output logic [N_SUB-1:0][2:0]  lvl,
  output logic [N_SUB-1:0]       ext,
  output logic [2:0]             arb_glob,
  output logic [1:0]             vec_base
);
  logic [N_SUB-1:0]      flag_q, flag_d;
  logic [N_SUB-1:0]      arm_q, arm_d;
  logic [N_SUB-1:0][2:0] lvl_q, lvl_d;
  logic [N_SUB-1:0]      ext_q, ext_d;
  logic [2:0]            glob_q, glob_d;
  logic [1:0]            base_q, base_d;
  logic                  glob_sel;

  assign glob_sel = (addr == '0);

  // next state
  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    lvl_d  = lvl_q;
    ext_d  = ext_q;
    glob_d = glob_q;
    base_d = base_q;
    if (wr_en && glob_sel) begin
      glob_d = wdata[GARB_LSB +: 3];
      base_d = wdata[BASE_LSB +: 2];
    end
    for (int i = 0; i < N_SUB; i++) begin
      if (addr == ADDR_W'(i + 1)) begin
        if (wr_en) begin
          lvl_d[i] = wdata[LVL_LSB +: 3];
          ext_d[i] = wdata[EXT_BIT];
          arm_d[i] = 1'b0;
          if (arm_q[i] && !wdata[FLAG_BIT]) flag_d[i] = 1'b0;
        end else if (rd_en && flag_q[i]) begin
          arm_d[i] = 1'b1;
        end
      end
      if (evt_set[i]) flag_d[i] = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
      lvl_q  <= '0;
      ext_q  <= '0;
      glob_q <= '0;
      base_q <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
      lvl_q  <= lvl_d;
      ext_q  <= ext_d;
      glob_q <= glob_d;
      base_q <= base_d;
    end
  end

  // read mux, unused bits and addresses give zero
  always_comb begin
    rdata = '0;
    if (glob_sel) begin
      rdata[GARB_LSB +: 3] = glob_q;
      rdata[BASE_LSB +: 2] = base_q;
    end
    for (int i = 0; i < N_SUB; i++) begin
      if (addr == ADDR_W'(i + 1)) begin
        rdata[FLAG_BIT]      = flag_q[i];
        rdata[LVL_LSB +: 3]  = lvl_q[i];
        rdata[EXT_BIT]       = ext_q[i];
      end
    end
  end

  assign flag     = flag_q;
  assign lvl      = lvl_q;
  assign ext      = ext_q;
  assign arb_glob = glob_q;
  assign vec_base = base_q;
endmodule

// File: rtl/tic_sel.sv
module tic_sel
  import tic_pkg::*;
#(
  parameter int N_SUB = 4,
  localparam int IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
  input  logic [N_SUB-1:0]      flag,
  input  logic [N_SUB-1:0][2:0] lvl,
  input  lvl_t                  ipl_mask,
  input  lvl_t                  iack_level,
  output lvl_t                  irq_level,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_idx
);
  logic [N_SUB-1:0] joins;

  for (genvar g = 0; g < N_SUB; g++) begin : g_qual
    assign joins[g] = flag[g] && (lvl[g] != 3'd0) &&
                      ((lvl[g] > ipl_mask) || (lvl[g] == 3'd7));
  end

  always_comb begin
    irq_level = 3'd0;
    for (int i = 0; i < N_SUB; i++) begin
      if (joins[i] && (lvl[i] > irq_level)) irq_level = lvl[i];
    end
  end

  // scan from the top so the lowest index is the last to claim
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N_SUB - 1; i >= 0; i--) begin
      if (joins[i] && (lvl[i] == iack_level)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tic_vec.sv
module tic_vec
  import tic_pkg::*;
#(
  parameter int N_SUB     = 4,
  parameter int FIRST_NUM = 6,
  localparam int IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iack_valid,
  input  logic [3:0]         iack_win_id,
  input  logic               hit,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic [N_SUB-1:0]   ext,
  input  logic [2:0]         arb_glob,
  input  logic [1:0]         vec_base,
  output logic               arb_drive,
  output logic [3:0]         arb_id,
  output logic               vec_valid,
  output logic [7:0]         vec
);
  logic [3:0] id_raw;
  logic       match;
  logic       vv_q, vv_d;
  logic [7:0] vec_q, vec_d;
  logic       vec_ld;

  assign id_raw    = {ext[hit_idx], arb_glob};
  assign arb_drive = iack_valid && hit;
  assign arb_id    = arb_drive ? id_raw : 4'd0;
  assign match     = arb_drive && (iack_win_id == id_raw);

  always_comb begin
    vv_d   = match;
    vec_ld = match;
    vec_d  = {vec_base, VNUM_W'(FIRST_NUM) + VNUM_W'(hit_idx)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      vv_q <= vv_d;
      if (vec_ld) vec_q <= vec_d;
    end
  end

  assign vec_valid = vv_q;
  assign vec       = vec_q;
endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl
  import tic_pkg::*;
#(
  parameter int N_SUB     = 4,
  parameter int ADDR_W    = 4,
  parameter int FIRST_NUM = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [N_SUB-1:0]  evt_set,
  input  logic [2:0]        ipl_mask,
  output logic [2:0]        irq_level,
  input  logic              iack_valid,
  input  logic [2:0]        iack_level,
  input  logic [3:0]        iack_win_id,
  output logic              arb_drive,
  output logic [3:0]        arb_id,
  output logic              vec_valid,
  output logic [7:0]        vec
);
  localparam int IDX_W = (N_SUB > 1) ? $clog2(N_SUB) : 1;

  logic [1:0]            rs_q;
  logic                  rst_core_n;
  logic [N_SUB-1:0]      flag;
  logic [N_SUB-1:0][2:0] lvl;
  logic [N_SUB-1:0]      ext;
  logic [2:0]            arb_glob;
  logic [1:0]            vec_base;
  logic                  hit;
  logic [IDX_W-1:0]      hit_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  tic_regs #(.N_SUB(N_SUB), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .evt_set(evt_set),
    .rdata(reg_rdata), .flag(flag), .lvl(lvl), .ext(ext),
    .arb_glob(arb_glob), .vec_base(vec_base)
  );

  tic_sel #(.N_SUB(N_SUB)) u_sel (
    .flag(flag), .lvl(lvl), .ipl_mask(ipl_mask), .iack_level(iack_level),
    .irq_level(irq_level), .hit(hit), .hit_idx(hit_idx)
  );

  tic_vec #(.N_SUB(N_SUB), .FIRST_NUM(FIRST_NUM)) u_vec (
    .clk(clk), .rst_n(rst_core_n), .iack_valid(iack_valid),
    .iack_win_id(iack_win_id), .hit(hit), .hit_idx(hit_idx), .ext(ext),
    .arb_glob(arb_glob), .vec_base(vec_base), .arb_drive(arb_drive),
    .arb_id(arb_id), .vec_valid(vec_valid), .vec(vec)
  );
endmodule

// File: rtl/timer_irq_ctrl_chk.sv
module timer_irq_ctrl_chk #(
  parameter int N_SUB     = 4,
  parameter int ADDR_W    = 4,
  parameter int FIRST_NUM = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_rdata,
  input logic [2:0]        ipl_mask,
  input logic [2:0]        irq_level,
  input logic              iack_valid,
  input logic [2:0]        iack_level,
  input logic [3:0]        iack_win_id,
  input logic              arb_drive,
  input logic [3:0]        arb_id,
  input logic              vec_valid,
  input logic [7:0]        vec
);
  // R3
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0 && irq_level != 3'd7) |-> (irq_level > ipl_mask));

  // R4
  ack_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_drive |-> (iack_level <= irq_level) && (iack_level != 3'd0));

  // R5
  drive_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_drive |-> iack_valid);

  // R5
  id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_drive |-> (arb_id == 4'd0));

  // R6
  vec_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(arb_drive) && ($past(arb_id) == $past(iack_win_id))));

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((vec[5:0] >= 6'(FIRST_NUM)) && (vec[5:0] < 6'(FIRST_NUM + N_SUB))));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(N_SUB)) |-> (reg_rdata == 16'd0));
endmodule

bind timer_irq_ctrl timer_irq_ctrl_chk #(
  .N_SUB(N_SUB), .ADDR_W(ADDR_W), .FIRST_NUM(FIRST_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ipl_mask(ipl_mask), .irq_level(irq_level), .iack_valid(iack_valid),
  .iack_level(iack_level), .iack_win_id(iack_win_id), .arb_drive(arb_drive),
  .arb_id(arb_id), .vec_valid(vec_valid), .vec(vec)
);

// File: tb/tb_timer_irq_ctrl.sv
module tb_timer_irq_ctrl;
  localparam int N     = 4;
  localparam int AW    = 4;
  localparam int FIRST = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;
  logic [15:0]   reg_wdata, reg_rdata;
  logic [N-1:0]  evt_set;
  logic [2:0]    ipl_mask, irq_level, iack_level;
  logic          iack_valid, arb_drive, vec_valid;
  logic [3:0]    iack_win_id, arb_id;
  logic [7:0]    vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_flag [N];
  int m_lvl  [N];
  int m_ext  [N];
  int m_glob, m_base;

  always #4 clk = ~clk;

  timer_irq_ctrl #(.N_SUB(N), .ADDR_W(AW), .FIRST_NUM(FIRST)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_set(evt_set), .ipl_mask(ipl_mask), .irq_level(irq_level),
    .iack_valid(iack_valid), .iack_level(iack_level),
    .iack_win_id(iack_win_id), .arb_drive(arb_drive), .arb_id(arb_id),
    .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(a);
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = '0;
  endtask

  task automatic pulse(input int ev);
    @(negedge clk);
    evt_set = N'(ev);
    @(negedge clk);
    evt_set = '0;
  endtask

  function automatic int word(input int i);
    return (m_flag[i] << 15) | (m_lvl[i] << 8) | (m_ext[i] << 4);
  endfunction

  function automatic bit joins(input int i, input int mask);
    return m_flag[i] != 0 && m_lvl[i] != 0 && (m_lvl[i] > mask || m_lvl[i] == 7);
  endfunction

  function automatic int exp_level(input int mask);
    int best = 0;
    for (int i = 0; i < N; i++)
      if (joins(i, mask) && m_lvl[i] > best) best = m_lvl[i];
    return best;
  endfunction

  function automatic int find(input int lv, input int mask);
    for (int i = 0; i < N; i++)
      if (joins(i, mask) && m_lvl[i] == lv) return i;
    return -1;
  endfunction

  // read then write with flag bit 0 and level 0: clears every flag
  task automatic clear_all();
    int d;
    for (int i = 0; i < N; i++) begin
      rd(i + 1, d);
      m_flag[i] = 0; m_lvl[i] = 0; m_ext[i] = 0;
      wr(i + 1, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int d, idx, eid;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    evt_set = '0; ipl_mask = '0; iack_valid = 0; iack_level = '0; iack_win_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq_level", int'(irq_level), 0);
    chk("R1 vec_valid", int'(vec_valid), 0);
    for (int a = 0; a <= N; a++) begin
      rd(a, d);
      chk("R1 reg reset", d, 0);
    end

    // sweep flag and level patterns; subs 0/2 and 1/3 share a level (R7 ties)
    for (int p = 0; p < 16; p++) begin
      m_glob = p % 8; m_base = (p / 2) % 4;
      wr(0, (m_base << 8) | m_glob);
      for (int i = 0; i < N; i++) begin
        rd(i + 1, d);
        m_lvl[i] = (p + (i % 2) * 3) % 8;
        m_ext[i] = (p >> i) & 1;
        m_flag[i] = 0;
        wr(i + 1, word(i));
      end
      pulse(p);
      for (int i = 0; i < N; i++) m_flag[i] = (p >> i) & 1;
      for (int i = 0; i < N; i++) begin
        rd(i + 1, d);
        chk("R10 flag set by event / readback", d, word(i));
      end
      for (int m = 0; m < 8; m++) begin
        @(negedge clk); ipl_mask = 3'(m);
        #1 chk("R2 R3 R4 irq_level", int'(irq_level), exp_level(m));
      end
      @(negedge clk); ipl_mask = 3'd0;
      for (int lv = 1; lv < 8; lv++) begin
        for (int id = 0; id < 16; id++) begin
          idx = find(lv, 0);
          eid = (idx >= 0) ? ((m_ext[idx] << 3) | m_glob) : 0;
          @(negedge clk);
          iack_valid = 1'b1; iack_level = 3'(lv); iack_win_id = 4'(id);
          #1;
          chk("R5 R7 arb_drive", int'(arb_drive), (idx >= 0) ? 1 : 0);
          chk("R5 R7 arb_id", int'(arb_id), eid);
          @(posedge clk); #1;
          iack_valid = 1'b0;
          chk("R6 vec_valid", int'(vec_valid), (idx >= 0 && id == eid) ? 1 : 0);
          if (idx >= 0 && id == eid)
            chk("R6 R7 vec", int'(vec), (m_base << 6) | (FIRST + idx));
        end
      end
    end

    // R9 flag clear handshake on submodule 0
    clear_all();
    @(negedge clk); ipl_mask = 3'd0;
    wr(1, 16'h0100); m_lvl[0] = 1;
    pulse(1);
    wr(1, 16'h0100);
    rd(1, d); chk("R9 write 0 without read keeps flag", d, 16'h8100);
    wr(1, 16'h8100);
    rd(1, d); chk("R9 write 1 keeps flag", d, 16'h8100);
    chk("R2 request visible", int'(irq_level), 1);
    wr(1, 16'h0100);
    rd(1, d); chk("R9 read then write 0 clears", d, 16'h0100);
    chk("R9 request dropped", int'(irq_level), 0);

    // R10 event beats a clearing write in the same cycle
    pulse(1);
    rd(1, d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(1); reg_wdata = 16'h0100; evt_set = 4'b0001;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; evt_set = '0;
    rd(1, d); chk("R10 set wins over clear", d, 16'h8100);

    // R2 level zero masks a set flag
    wr(1, 16'h8000);
    #1 chk("R2 level 0 masks", int'(irq_level), 0);
    rd(1, d); chk("R2 level 0 readback", d, 16'h8000);

    // R8 unused bits and unmapped addresses
    wr(0, 16'hFFFF);
    rd(0, d); chk("R8 global unused bits", d, 16'h0307);
    wr(2, 16'hFFFF);
    rd(2, d); chk("R8 control unused bits, flag not set by write", d, 16'h0710);
    for (int a = N + 1; a < (1 << AW); a++) begin
      wr(a, 16'hFFFF);
      rd(a, d); chk("R8 unmapped reads zero", d, 0);
    end
    rd(0, d); chk("R8 global untouched", d, 16'h0307);
    rd(1, d); chk("R8 sub0 untouched", d, 16'h8000);
    rd(2, d); chk("R8 sub1 untouched", d, 16'h0710);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule